// File: doc/BRIEF.md
# Row State Collector

This block is the middle stage of a three-stage zero-suppression pipeline for a pixel sensor read out row by row. Upstream, eighteen parallel bank sparsifiers each reduce their slice of one pixel row to a short list of hit states. Each state is a 6-bit column address plus a 2-bit length code. Each bank reports a count, up to six states, and a flag set when it had more states than it could hold. Downstream, a buffered memory stores the merged records.

On a row strobe the collector takes a snapshot of every bank's list. One cycle later it emits a header word that carries the row number, the number of entries that follow and an overflow bit. It then emits the accepted states one per cycle, with each state widened by the index of the bank it came from. Banks are visited from index 0 upward, and inside a bank the states keep their slot order. The record stops at nine entries, and the rest are dropped. Empty banks cost no cycles, so a row of n entries takes n+1 output cycles and the collector is free again at the next edge. It is therefore ready for the next row within ten cycles in the worst case.

Top module: `row_collector`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is low.
- R2: A strobe on `row_valid` is accepted when no entry is pending. The header is valid one cycle later with `out_is_header` high. Its layout is `out_word[14:5]` = row number, `[4:1]` = entry count, `[0]` = overflow.
- R3: Entry words follow the header in consecutive cycles, and their number equals the count in the header. The entry count is the smaller of the summed bank counts and 9. An entry word has bits [14:13] zero, bank index in [12:8], column in [7:2] and length code in [1:0].
- R4: Entries appear in ascending bank order, and within a bank in ascending slot order. Slot j of bank b is read from `bank_slots[(b*6+j)*8 +: 8]`, with column in the upper 6 bits and length in the lower 2. The count of bank b is `bank_cnt[b*3 +: 3]`.
- R5: Each entry carries the index of the bank that supplied it. Banks with a zero count contribute nothing and cause no idle cycle.
- R6: When the summed counts exceed 9, only the first 9 entries in R4 order are emitted and the overflow bit is set. A sum of exactly 9 does not set it.
- R7: A set `bank_ovf` bit for any bank sets the header overflow bit.
- R8: A bank count above 6 is handled as 6 and sets the header overflow bit.
- R9: A `row_valid` strobe that arrives while entries of an earlier row are still pending is ignored. The output then continues the earlier row.
- R10: With nothing pending and no strobe, `out_valid` is low on the next cycle. A strobe at the edge right after the last entry is accepted, so rows can be spaced n+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | Row strobe: bank lists and row number are valid |
| row_num | input | 10 | Row number for the header |
| bank_cnt | input | 54 | Per-bank state count, 3 bits per bank |
| bank_ovf | input | 18 | Per-bank flag: bank dropped states |
| bank_slots | input | 864 | Per-bank state slots, 6 slots of 8 bits per bank |
| out_valid | output | 1 | Output word is valid |
| out_is_header | output | 1 | Output word is a row header |
| out_word | output | 15 | Header or tagged entry |

## Verification
The header for an accepted strobe is due exactly one cycle after the edge that samples it. Entry k of that row is due k cycles after the header, and `out_valid` falls on the cycle after the last entry unless a new row is accepted at that edge. The bench drives inputs on falling edges and keeps a queue of expected words, one per future rising edge. The bench decides acceptance by whether that queue is empty. It compares the registered outputs on the next falling edge, every cycle, so that a missing, extra, early or late word shows up as a miscompare at the cycle where it occurs.

// File: rtl/rc_pkg.sv
package rc_pkg;

    localparam int COL_W  = 6;
    localparam int LEN_W  = 2;
    localparam int SLOT_W = COL_W + LEN_W;

    localparam int DEF_BANKS = 18;
    localparam int DEF_DEPTH = 6;
    localparam int DEF_CAP   = 9;
    localparam int DEF_ROW_W = 10;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [LEN_W-1:0] len;
    } slot_t;

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rc_capture.sv
module rc_capture
    import rc_pkg::*;
#(
    parameter int NUM_BANKS  = DEF_BANKS,
    parameter int BANK_DEPTH = DEF_DEPTH,
    parameter int ROW_CAP    = DEF_CAP,
    localparam int CNT_W     = $clog2(BANK_DEPTH + 1),
    localparam int TOT_W     = $clog2(NUM_BANKS * BANK_DEPTH + 1),
    localparam int HCNT_W    = $clog2(ROW_CAP + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  load,
    input  logic [NUM_BANKS*CNT_W-1:0]            cnt_in,
    input  logic [NUM_BANKS-1:0]                  ovf_in,
    input  logic [NUM_BANKS*BANK_DEPTH*SLOT_W-1:0] slots_in,
    output logic [CNT_W-1:0]                      cnt_q  [NUM_BANKS],
    output slot_t                                 slot_q [NUM_BANKS][BANK_DEPTH],
    output logic [HCNT_W-1:0]                     hdr_cnt_d,
    output logic                                  hdr_ovf_d
);

    logic [CNT_W-1:0] raw_cnt [NUM_BANKS];
    logic [CNT_W-1:0] cl_cnt  [NUM_BANKS];
    slot_t            slot_d  [NUM_BANKS][BANK_DEPTH];
    logic [TOT_W-1:0] total;
    logic             any_clamp;

    // unpack the flat bank inputs
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign raw_cnt[b] = cnt_in[b*CNT_W +: CNT_W];
        for (genvar j = 0; j < BANK_DEPTH; j++) begin : g_slot
            assign slot_d[b][j] = slot_t'(slots_in[(b*BANK_DEPTH+j)*SLOT_W +: SLOT_W]);
        end
    end

    // clamp counts to the bank depth and total them
    always_comb begin
        total     = '0;
        any_clamp = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (raw_cnt[b] > CNT_W'(BANK_DEPTH)) begin
                cl_cnt[b] = CNT_W'(BANK_DEPTH);
                any_clamp = 1'b1;
            end else begin
                cl_cnt[b] = raw_cnt[b];
            end
            total = total + TOT_W'(cl_cnt[b]);
        end
    end

    assign hdr_cnt_d = (total > TOT_W'(ROW_CAP)) ? HCNT_W'(ROW_CAP) : total[HCNT_W-1:0];
    assign hdr_ovf_d = (|ovf_in) | any_clamp | (total > TOT_W'(ROW_CAP));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                cnt_q[b] <= '0;
                for (int j = 0; j < BANK_DEPTH; j++) slot_q[b][j] <= '0;
            end
        end else if (load) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                cnt_q[b] <= cl_cnt[b];
                for (int j = 0; j < BANK_DEPTH; j++) slot_q[b][j] <= slot_d[b][j];
            end
        end
    end

endmodule

// File: rtl/rc_picker.sv
module rc_picker
    import rc_pkg::*;
#(
    parameter int NUM_BANKS  = DEF_BANKS,
    parameter int BANK_DEPTH = DEF_DEPTH,
    localparam int CNT_W     = $clog2(BANK_DEPTH + 1),
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic [CNT_W-1:0]  cnt [NUM_BANKS],
    input  logic [BANK_W-1:0] cur_bank,
    input  logic [CNT_W-1:0]  cur_idx,
    output logic              found,
    output logic [BANK_W-1:0] sel_bank,
    output logic [CNT_W-1:0]  sel_idx
);

    // lowest bank at or above the cursor that still has a state left
    always_comb begin
        found    = 1'b0;
        sel_bank = '0;
        sel_idx  = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            logic [CNT_W-1:0] start;
            start = (BANK_W'(b) == cur_bank) ? cur_idx : '0;
            if (BANK_W'(b) >= cur_bank && start < cnt[b]) begin
                found    = 1'b1;
                sel_bank = BANK_W'(b);
                sel_idx  = start;
            end
        end
    end

endmodule

// File: rtl/row_collector.sv
module row_collector
    import rc_pkg::*;
#(
    parameter int NUM_BANKS  = DEF_BANKS,
    parameter int BANK_DEPTH = DEF_DEPTH,
    parameter int ROW_CAP    = DEF_CAP,
    parameter int ROW_W      = DEF_ROW_W,
    localparam int CNT_W     = $clog2(BANK_DEPTH + 1),
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int HCNT_W    = $clog2(ROW_CAP + 1),
    localparam int ENT_W     = BANK_W + SLOT_W,
    localparam int OUT_W     = max_int(ROW_W + HCNT_W + 1, ENT_W)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   row_valid,
    input  logic [ROW_W-1:0]                       row_num,
    input  logic [NUM_BANKS*CNT_W-1:0]             bank_cnt,
    input  logic [NUM_BANKS-1:0]                   bank_ovf,
    input  logic [NUM_BANKS*BANK_DEPTH*SLOT_W-1:0] bank_slots,
    output logic                                   out_valid,
    output logic                                   out_is_header,
    output logic [OUT_W-1:0]                       out_word
);

    logic [CNT_W-1:0]  cnt_q  [NUM_BANKS];
    slot_t             slot_q [NUM_BANKS][BANK_DEPTH];
    logic [HCNT_W-1:0] hdr_cnt_d;
    logic              hdr_ovf_d;
    logic [HCNT_W-1:0] left;
    logic [BANK_W-1:0] cur_bank;
    logic [CNT_W-1:0]  cur_idx;
    logic              pick_found;
    logic [BANK_W-1:0] sel_bank;
    logic [CNT_W-1:0]  sel_idx;
    logic              load;

    assign load = row_valid && (left == '0);

    rc_capture #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_DEPTH(BANK_DEPTH),
        .ROW_CAP   (ROW_CAP)
    ) i_capture (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .cnt_in   (bank_cnt),
        .ovf_in   (bank_ovf),
        .slots_in (bank_slots),
        .cnt_q    (cnt_q),
        .slot_q   (slot_q),
        .hdr_cnt_d(hdr_cnt_d),
        .hdr_ovf_d(hdr_ovf_d)
    );

    rc_picker #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_DEPTH(BANK_DEPTH)
    ) i_picker (
        .cnt     (cnt_q),
        .cur_bank(cur_bank),
        .cur_idx (cur_idx),
        .found   (pick_found),
        .sel_bank(sel_bank),
        .sel_idx (sel_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            left          <= '0;
            cur_bank      <= '0;
            cur_idx       <= '0;
            out_valid     <= 1'b0;
            out_is_header <= 1'b0;
            out_word      <= '0;
        end else if (load) begin
            left          <= hdr_cnt_d;
            cur_bank      <= '0;
            cur_idx       <= '0;
            out_valid     <= 1'b1;
            out_is_header <= 1'b1;
            out_word      <= OUT_W'({row_num, hdr_cnt_d, hdr_ovf_d});
        end else if (left != '0) begin
            left          <= left - 1'b1;
            cur_bank      <= sel_bank;
            cur_idx       <= sel_idx + 1'b1;
            out_valid     <= 1'b1;
            out_is_header <= 1'b0;
            out_word      <= OUT_W'({sel_bank, slot_q[sel_bank][sel_idx]});
        end else begin
            out_valid     <= 1'b0;
            out_is_header <= 1'b0;
            out_word      <= '0;
        end
    end

    // ---------------- assertions ----------------
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !out_valid);

    a_r2_header_follows: assert property (@(posedge clk) disable iff (rst)
        (row_valid && left == '0) |=> (out_valid && out_is_header));

    a_r3_entry_available: assert property (@(posedge clk) disable iff (rst)
        (left != '0) |-> pick_found);

    a_r6_pending_capped: assert property (@(posedge clk) disable iff (rst)
        left <= HCNT_W'(ROW_CAP));

    a_r4_bank_ascending: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_header && $past(out_valid && !out_is_header))
        |-> (out_word[ENT_W-1:SLOT_W] >= $past(out_word[ENT_W-1:SLOT_W])));

    a_r9_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (row_valid && left != '0) |=> (out_valid && !out_is_header));

    a_r10_idle_low: assert property (@(posedge clk) disable iff (rst)
        (!row_valid && left == '0) |=> !out_valid);

endmodule

// File: tb/test_row_collector.sv
module test_row_collector;

    localparam int NB = 18;
    localparam int ND = 6;
    localparam int CAP = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        row_valid = 1'b0;
    logic [9:0]  row_num = '0;
    logic [53:0] bank_cnt = '0;
    logic [17:0] bank_ovf = '0;
    logic [863:0] bank_slots = '0;
    logic        out_valid;
    logic        out_is_header;
    logic [14:0] out_word;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    string idle_tag = "R1";
    string cur_tag  = "R2";
    int unsigned lfsr = 32'h1ace_b00c;

    logic [14:0] q_word[$];
    bit          q_hdr[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    row_collector i_row_collector (
        .clk(clk), .rst(rst), .row_valid(row_valid), .row_num(row_num),
        .bank_cnt(bank_cnt), .bank_ovf(bank_ovf), .bank_slots(bank_slots),
        .out_valid(out_valid), .out_is_header(out_is_header), .out_word(out_word)
    );

    function automatic int unsigned rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // reference model: build the expected record from the current inputs
    task automatic model_accept();
        int total = 0;
        int n;
        bit ovf = 0;
        int emitted = 0;
        for (int b = 0; b < NB; b++) begin
            int c = int'(bank_cnt[b*3 +: 3]);
            if (c > ND) begin c = ND; ovf = 1; end
            total += c;
            if (bank_ovf[b]) ovf = 1;
        end
        if (total > CAP) ovf = 1;
        n = (total > CAP) ? CAP : total;
        q_word.push_back({row_num, 4'(n), ovf});
        q_hdr.push_back(1'b1);
        q_tag.push_back(cur_tag);
        for (int b = 0; b < NB; b++) begin
            int c = int'(bank_cnt[b*3 +: 3]);
            if (c > ND) c = ND;
            for (int j = 0; j < c; j++) begin
                if (emitted < CAP) begin
                    q_word.push_back({2'b00, 5'(b), bank_slots[(b*ND+j)*8 +: 8]});
                    q_hdr.push_back(1'b0);
                    q_tag.push_back(cur_tag);
                    emitted++;
                end
            end
        end
    endtask

    task automatic compare();
        vectors++;
        if (q_word.size() == 0) begin
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL %s: out_valid=%b expected 0", idle_tag, out_valid);
            end
        end else begin
            logic [14:0] w = q_word.pop_front();
            bit h = q_hdr.pop_front();
            string t = q_tag.pop_front();
            if (out_valid !== 1'b1 || out_is_header !== h || out_word !== w) begin
                errors++;
                $display("FAIL %s: valid=%b hdr=%b word=%h expected valid=1 hdr=%b word=%h",
                         t, out_valid, out_is_header, out_word, h, w);
            end
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        compare();
        row_valid = 1'b0;
    endtask

    // strobe a row; the model accepts it only when nothing is pending (R9)
    task automatic send_row(input logic [9:0] r);
        row_num = r;
        row_valid = 1'b1;
        if (q_word.size() == 0) model_accept();
        cycle();
    endtask

    task automatic clear_banks();
        bank_cnt = '0;
        bank_ovf = '0;
        bank_slots = '0;
    endtask

    task automatic fill_bank(input int b, input int n);
        bank_cnt[b*3 +: 3] = 3'(n);
        for (int j = 0; j < ND; j++)
            bank_slots[(b*ND+j)*8 +: 8] = {6'(b*2 + j*7 + 1), 2'(j)};
    endtask

    task automatic drain();
        while (q_word.size() != 0) cycle();
        cycle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); @(negedge clk); compare();
        end
        rst = 1'b0;
        cycle();
        idle_tag = "R10";

        // R2 R3: single bank, three states
        cur_tag = "R2";
        clear_banks(); fill_bank(0, 3);
        send_row(10'd5); drain();

        // R4 R5: states spread over sparse banks including the last one
        cur_tag = "R5";
        clear_banks(); fill_bank(2, 2); fill_bank(9, 1); fill_bank(17, 3);
        send_row(10'd575); drain();

        // R3: empty row, header only
        cur_tag = "R3";
        clear_banks();
        send_row(10'd1); drain();

        // R6: twelve states, truncated to nine with overflow
        cur_tag = "R6";
        clear_banks(); fill_bank(1, 6); fill_bank(4, 4); fill_bank(5, 2);
        send_row(10'd100); drain();

        // R6: exactly nine states, no overflow
        cur_tag = "R6";
        clear_banks(); fill_bank(0, 6); fill_bank(3, 3);
        send_row(10'd101); drain();

        // R7: a bank flags overflow on a light row
        cur_tag = "R7";
        clear_banks(); fill_bank(6, 1); bank_ovf[11] = 1'b1;
        send_row(10'd200); drain();

        // R8: count of 7 handled as 6 with overflow
        cur_tag = "R8";
        clear_banks(); fill_bank(7, 6); bank_cnt[7*3 +: 3] = 3'd7;
        send_row(10'd300); drain();

        // R9 R10: strobes during emission are ignored; the first one after
        // the last entry is accepted
        cur_tag = "R9";
        clear_banks(); fill_bank(3, 4);
        send_row(10'd400);
        clear_banks(); fill_bank(8, 2);
        for (int i = 0; i < 6; i++) send_row(10'(401 + i));
        drain();

        // R4: pseudo-random rows at varying spacing
        cur_tag = "R4";
        for (int k = 0; k < 300; k++) begin
            clear_banks();
            for (int b = 0; b < NB; b++) begin
                int c = int'(rnd() % 16);
                c = (c < 10) ? 0 : c - 9;
                bank_cnt[b*3 +: 3] = 3'(c);
                bank_ovf[b] = ((rnd() % 64) == 0);
                for (int j = 0; j < ND; j++)
                    bank_slots[(b*ND+j)*8 +: 8] = 8'(rnd());
            end
            send_row(10'(rnd()));
            for (int w = 0; w < int'(rnd() % 12); w++) cycle();
        end
        drain();

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule